// File: doc/BRIEF.md
# Serial Lane Frame Encoder (Transmit Side)

This block forms the transmit frames for one serial lane. Each 14-bit data word is XORed with 14 bits of an additive pseudo-random sequence. A clock bit is then added that inverts on every scrambled frame. Last, a disparity bit is chosen, and it either passes the first 15 bits unchanged or inverts them, so that the running DC balance of the lane stays within ±16. The resulting 16-bit frame goes to a serializer, which sends it least significant bit first.

The lane idles until a synchronization request arrives. After that it sends a fixed start-up sequence in two parts. The first part is 32 alignment frames that need no descrambling, so the receiver can find the frame boundary. The second part is 32 frames that carry the scrambler sequence alone, so the receiver can lock its own scrambler. User data follows the second part. A frame-enable strobe sets the frame rate. The scrambler seed is a parameter, so each lane can start from its own point in the sequence.

Top module: `lane_frame_enc`

## Requirements
- R1: After reset, frame_o is 0 and data_mode_o is 0. Until the first SYNC is accepted, frame_en_i leaves frame_o at 0.
- R2: A data frame carries (data_i XOR prbs) in bits [13:0], the clock bit in bit 14 and the disparity bit in bit 15. When the disparity bit is 1, bits [14:0] are sent inverted.
- R3: The scrambler is a 17-bit state s. Each step outputs s[0], shifts s right by one and writes s[0]^s[3] into s[16]; the first output of a frame is prbs bit 0. A frame takes 14 steps. The state loads SEED when a SYNC is accepted, and it advances only on prbs-only frames and data frames.
- R4: The clock bit, taken before any inversion, is 0 in the first prbs-only frame and inverts on every later prbs-only frame or data frame.
- R5: Frame disparity is 2·(number of ones in the 16 bits) − 16. The disparity bit is 0 when the running disparity plus the disparity of the frame with bit 15 = 0 stays within −16..+16. Otherwise it is 1. The running disparity then adds the disparity of the frame actually sent.
- R6: The running disparity is cleared to 0 when a SYNC is accepted and never leaves −16..+16.
- R7: A SYNC is accepted on the first frame_en_i cycle at or after it. That frame and the next 31 are alignment frames, alternating 16'hFF00 and 16'h00FF and starting with 16'hFF00.
- R8: The 32 frames after the alignment frames carry the scrambler output alone as payload, with clock-bit and disparity processing applied.
- R9: With a SEED whose low 14 bits differ from 14'h00FF (the default is 17'h1ACE5), the first prbs-only frame is neither 16'hFF00 nor 16'h00FF.
- R10: A SYNC pulse raised in a cycle without frame_en_i is held until the next frame_en_i cycle. A SYNC raised during the start-up sequence or during data restarts the sequence.
- R11: data_mode_o rises in the cycle the 64th sequence frame appears on frame_o, and it falls in the cycle the first alignment frame of the next accepted SYNC appears.
- R12: frame_o updates one clock after a frame_en_i cycle. In a cycle without frame_en_i, frame_o, data_mode_o and the scrambler all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en_i | input | 1 | One frame is produced in each cycle this is high |
| sync_i | input | 1 | Synchronization request, may be a single cycle |
| data_i | input | 14 | Payload word, sampled on frame_en_i cycles in data mode |
| frame_o | output | 16 | Encoded frame, registered |
| data_mode_o | output | 1 | High while the lane carries user data |

## Verification
The hardest case to reach is the inverted branch of the disparity choice, because random scrambled data almost never drives the running disparity past ±16. To reach it, the bench uses its own model of the scrambler to choose data_i equal to the complement of the next prbs slice. Every scrambled payload is then all ones, which forces inversions on alternate frames. The bench also chooses data_i equal to the prbs slice, which gives all-zero payloads. It also covers a SYNC pulse that falls between frame strobes, restarts in the middle of the alignment phase and in the middle of data, and throttled frame strobes.

// File: rtl/lane_enc_pkg.sv
// Shared types for the lane frame encoder.
// Assumes: nothing beyond IEEE 1800-2017.
package lane_enc_pkg;

    // Sequencer phase of the lane.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_PAS   = 2'd2,
        PH_DATA  = 2'd3
    } phase_t;

    // Kind of frame produced in the current cycle.
    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_ALIGN = 2'd1,
        FK_PRBS  = 2'd2,
        FK_DATA  = 2'd3
    } frame_kind_t;

endpackage

// File: rtl/lane_prbs_gen.sv
// Additive scrambler source: a Fibonacci LFSR that advances STEP positions per frame.
// Each step emits s[0], shifts right and feeds s[0]^s[TAP] into the top bit.
// Assumes: SEED is nonzero; load has priority over advance.
module lane_prbs_gen #(
    parameter int              LFSR_W = 17,
    parameter int              TAP    = 3,
    parameter int              STEP   = 14,
    parameter logic [LFSR_W-1:0] SEED = 17'h1ACE5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            adv_i,
    output logic [STEP-1:0] prbs_o
);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_nxt;

    // Unroll STEP single-bit shifts to get the slice and the next state.
    always_comb begin
        logic [LFSR_W-1:0] s;
        s = state_q;
        for (int i = 0; i < STEP; i++) begin
            prbs_o[i] = s[0];
            s = {s[0] ^ s[TAP], s[LFSR_W-1:1]};
        end
        state_nxt = s;
    end

    // Hold, reload with the seed, or advance by one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load_i) begin
            state_q <= SEED;
        end else if (adv_i) begin
            state_q <= state_nxt;
        end
    end

endmodule

// File: rtl/lane_disp_sel.sv
// Disparity selector: decides whether the 15 low frame bits are inverted so the
// running disparity stays within +/-RD_LIM, and returns the updated disparity.
// Assumes: rd_i already lies within +/-RD_LIM; purely combinational.
module lane_disp_sel #(
    parameter int PAY_W  = 14,
    parameter int RD_LIM = 16,
    parameter int RD_W   = 7
) (
    input  logic [PAY_W:0]          raw_i,
    input  logic signed [RD_W-1:0]  rd_i,
    output logic [PAY_W+1:0]        frame_o,
    output logic signed [RD_W-1:0]  rd_nxt_o
);

    localparam int FRM_W = PAY_W + 2;

    // Count ones, form the plain-frame disparity and pick the polarity.
    always_comb begin
        int ones;
        int d_plain;
        int total;
        ones = 0;
        for (int i = 0; i <= PAY_W; i++) begin
            ones = ones + int'(raw_i[i]);
        end
        d_plain = 2 * ones - FRM_W;
        total   = int'(rd_i) + d_plain;
        if (total > RD_LIM || total < -RD_LIM) begin
            frame_o  = {1'b1, ~raw_i};
            rd_nxt_o = RD_W'(int'(rd_i) - d_plain);
        end else begin
            frame_o  = {1'b0, raw_i};
            rd_nxt_o = RD_W'(total);
        end
    end

endmodule

// File: rtl/lane_seq_ctrl.sv
// Start-up sequencer: captures SYNC, walks the alignment and prbs-only phases
// of SEQ_LEN frames each, then stays in data mode until the next SYNC.
// Assumes: one frame per frame_en_i cycle; SYNC has priority over everything.
module lane_seq_ctrl
    import lane_enc_pkg::*;
#(
    parameter int SEQ_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_en_i,
    input  logic        sync_i,
    output frame_kind_t kind_o,
    output logic        idx_odd_o,
    output logic        restart_o,
    output logic        data_mode_o
);

    localparam int CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             accept;

    assign accept      = frame_en_i & (sync_i | pend_q);
    assign restart_o   = accept;
    assign data_mode_o = (phase_q == PH_DATA);

    // Decide what kind of frame this cycle produces.
    always_comb begin
        kind_o    = FK_NONE;
        idx_odd_o = 1'b0;
        if (accept) begin
            kind_o = FK_ALIGN;
        end else if (frame_en_i) begin
            case (phase_q)
                PH_ALIGN: begin
                    kind_o    = FK_ALIGN;
                    idx_odd_o = cnt_q[0];
                end
                PH_PAS:  kind_o = FK_PRBS;
                PH_DATA: kind_o = FK_DATA;
                default: kind_o = FK_NONE;
            endcase
        end
    end

    // Keep a SYNC that arrived between frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q <= 1'b0;
        end else if (sync_i) begin
            pend_q <= 1'b1;
        end
    end

    // Advance phase and frame index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (accept) begin
            phase_q <= PH_ALIGN;
            cnt_q   <= CNT_W'(1);
        end else if (frame_en_i) begin
            case (phase_q)
                PH_ALIGN: begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_PAS;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_PAS: begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    phase_q <= phase_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/lane_frame_enc.sv
// Lane frame encoder top: scrambles the payload, adds the clock bit, selects the
// disparity bit and muxes in the start-up sequence; frame_o is registered.
// Assumes: SEED low PAY_W bits differ from the low half-ones pattern so the
// first prbs-only frame cannot look like an alignment word.
module lane_frame_enc
    import lane_enc_pkg::*;
#(
    parameter int                PAY_W    = 14,
    parameter int                LFSR_W   = 17,
    parameter int                LFSR_TAP = 3,
    parameter int                SEQ_LEN  = 32,
    parameter int                RD_LIM   = 16,
    parameter logic [LFSR_W-1:0] SEED     = 17'h1ACE5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_en_i,
    input  logic             sync_i,
    input  logic [PAY_W-1:0] data_i,
    output logic [PAY_W+1:0] frame_o,
    output logic             data_mode_o
);

    localparam int FRM_W = PAY_W + 2;
    localparam int HALF  = FRM_W / 2;
    localparam int RD_W  = $clog2(RD_LIM) + 3;
    localparam logic [FRM_W-1:0] ALN_EVEN = {{HALF{1'b1}}, {(FRM_W-HALF){1'b0}}};
    localparam logic [FRM_W-1:0] ALN_ODD  = ~ALN_EVEN;

    frame_kind_t             kind;
    logic                    idx_odd;
    logic                    restart;
    logic                    emit_scr;
    logic [PAY_W-1:0]        prbs;
    logic [PAY_W-1:0]        payload;
    logic [FRM_W-1:0]        scr_frame;
    logic signed [RD_W-1:0]  rd_q;
    logic signed [RD_W-1:0]  rd_nxt;
    logic                    cb_q;
    logic [FRM_W-1:0]        frame_q;

    lane_seq_ctrl #(.SEQ_LEN(SEQ_LEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_en_i  (frame_en_i),
        .sync_i      (sync_i),
        .kind_o      (kind),
        .idx_odd_o   (idx_odd),
        .restart_o   (restart),
        .data_mode_o (data_mode_o)
    );

    assign emit_scr = (kind == FK_PRBS) || (kind == FK_DATA);

    lane_prbs_gen #(
        .LFSR_W (LFSR_W),
        .TAP    (LFSR_TAP),
        .STEP   (PAY_W),
        .SEED   (SEED)
    ) u_prbs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (restart),
        .adv_i  (emit_scr),
        .prbs_o (prbs)
    );

    // Payload: scrambler alone during the prbs phase, scrambled data afterwards.
    always_comb begin
        payload = (kind == FK_DATA) ? (data_i ^ prbs) : prbs;
    end

    lane_disp_sel #(
        .PAY_W  (PAY_W),
        .RD_LIM (RD_LIM),
        .RD_W   (RD_W)
    ) u_disp (
        .raw_i    ({cb_q, payload}),
        .rd_i     (rd_q),
        .frame_o  (scr_frame),
        .rd_nxt_o (rd_nxt)
    );

    // Clock bit: cleared by SYNC, inverted on every scrambled frame.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cb_q <= 1'b0;
        end else if (emit_scr) begin
            cb_q <= ~cb_q;
        end
    end

    // Running disparity: cleared by SYNC, updated on scrambled frames.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            rd_q <= '0;
        end else if (emit_scr) begin
            rd_q <= rd_nxt;
        end
    end

    // Output frame register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (kind == FK_ALIGN) begin
            frame_q <= idx_odd ? ALN_ODD : ALN_EVEN;
        end else if (emit_scr) begin
            frame_q <= scr_frame;
        end
    end

    assign frame_o = frame_q;

endmodule

// File: rtl/lane_frame_enc_chk.sv
// Checker for lane_frame_enc: timing, disparity bookkeeping and sequence start.
// Assumes: bound into lane_frame_enc, sees its registered running disparity.
module lane_frame_enc_chk #(
    parameter int PAY_W  = 14,
    parameter int RD_LIM = 16,
    parameter int RD_W   = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_en_i,
    input logic                   sync_i,
    input logic [PAY_W+1:0]       frame_o,
    input logic                   data_mode_o,
    input logic signed [RD_W-1:0] rd_q,
    input logic                   emit_scr
);

    localparam int FRM_W = PAY_W + 2;
    localparam logic [FRM_W-1:0] ALN_EVEN = {{(FRM_W/2){1'b1}}, {(FRM_W-FRM_W/2){1'b0}}};

    p_rd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_q) <= RD_LIM) && (int'(rd_q) >= -RD_LIM));

    p_rd_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emit_scr |=> int'(rd_q) == int'($past(rd_q)) + 2 * $countones(frame_o) - FRM_W);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en_i |=> $stable(frame_o) && $stable(data_mode_o));

    p_align_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en_i && sync_i) |=> (frame_o == ALN_EVEN) && !data_mode_o);

    p_cb_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_scr && data_mode_o) |=>
            ((frame_o[PAY_W] ^ frame_o[PAY_W+1]) != $past(frame_o[PAY_W] ^ frame_o[PAY_W+1])));

endmodule

bind lane_frame_enc lane_frame_enc_chk #(
    .PAY_W  (PAY_W),
    .RD_LIM (RD_LIM),
    .RD_W   (RD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_en_i  (frame_en_i),
    .sync_i      (sync_i),
    .frame_o     (frame_o),
    .data_mode_o (data_mode_o),
    .rd_q        (rd_q),
    .emit_scr    (emit_scr)
);

// File: tb/lane_frame_enc_tb_top.sv
// Scoreboard bench: the driver predicts each cycle's output and queues it,
// the monitor compares after every rising edge.
module lane_frame_enc_tb_top;

    localparam logic [16:0] SEED = 17'h1ACE5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_en_i = 1'b0;
    logic        sync_i = 1'b0;
    logic [13:0] data_i = '0;
    logic [15:0] frame_o;
    logic        data_mode_o;

    always #2 clk = ~clk;

    lane_frame_enc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_en_i  (frame_en_i),
        .sync_i      (sync_i),
        .data_i      (data_i),
        .frame_o     (frame_o),
        .data_mode_o (data_mode_o)
    );

    typedef struct {
        logic [15:0] f;
        logic        m;
        bit          first_pas;
        int          tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference model state.
    int          m_phase = 0;
    int          m_cnt   = 0;
    bit          m_pend  = 1'b0;
    logic [16:0] m_lfsr  = SEED;
    int          m_rd    = 0;
    logic        m_cb    = 1'b0;
    logic [15:0] m_frame = '0;
    logic [31:0] lcg     = 32'h1234_5678;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1 idle";
            2: return "R7 R10 alignment";
            3: return "R8 R3 R4 R5 R6 prbs-only";
            4: return "R2 R3 R4 R5 R6 R11 data";
            5: return "R12 hold";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [30:0] lfsr_step14(logic [16:0] s);
        logic [13:0] b;
        for (int i = 0; i < 14; i++) begin
            b[i] = s[0];
            s = {s[0] ^ s[3], s[16:1]};
        end
        return {s, b};
    endfunction

    // Build one scrambled frame and update model disparity and clock bit.
    task automatic model_scr(input logic [13:0] pay);
        logic [14:0] raw;
        int ones, d;
        raw  = {m_cb, pay};
        ones = 0;
        for (int i = 0; i < 15; i++) ones += int'(raw[i]);
        d = 2 * ones - 16;
        if (m_rd + d > 16 || m_rd + d < -16) begin
            m_frame = {1'b1, ~raw};
            m_rd    = m_rd - d;
        end else begin
            m_frame = {1'b0, raw};
            m_rd    = m_rd + d;
        end
        m_cb = ~m_cb;
    endtask

    // Drive one cycle. force_mode: 0 use data, 1 payload all ones, 2 payload all zeros.
    task automatic drive(input bit en, input bit sy, input logic [13:0] data, input int force_mode);
        exp_t        e;
        logic [30:0] st;
        bit          acc;
        @(negedge clk);
        e.first_pas = 1'b0;
        acc = en && (sy || m_pend);
        if (!acc && en && m_phase == 3 && force_mode != 0) begin
            st   = lfsr_step14(m_lfsr);
            data = (force_mode == 1) ? ~st[13:0] : st[13:0];
        end
        frame_en_i = en;
        sync_i     = sy;
        data_i     = data;
        if (acc) begin
            m_frame = 16'hFF00;
            m_phase = 1; m_cnt = 1; m_pend = 1'b0;
            m_lfsr = SEED; m_rd = 0; m_cb = 1'b0;
            e.tag = 2;
        end else begin
            if (sy) m_pend = 1'b1;
            if (!en) begin
                e.tag = 5;
            end else begin
                case (m_phase)
                    1: begin
                        m_frame = m_cnt[0] ? 16'h00FF : 16'hFF00;
                        m_cnt++;
                        if (m_cnt == 32) begin m_phase = 2; m_cnt = 0; end
                        e.tag = 2;
                    end
                    2: begin
                        st = lfsr_step14(m_lfsr);
                        m_lfsr = st[30:14];
                        e.first_pas = (m_cnt == 0);
                        model_scr(st[13:0]);
                        m_cnt++;
                        if (m_cnt == 32) begin m_phase = 3; m_cnt = 0; end
                        e.tag = 3;
                    end
                    3: begin
                        st = lfsr_step14(m_lfsr);
                        m_lfsr = st[30:14];
                        model_scr(data ^ st[13:0]);
                        e.tag = 4;
                    end
                    default: e.tag = 1;
                endcase
            end
        end
        e.f = m_frame;
        e.m = (m_phase == 3);
        q.push_back(e);
    endtask

    function automatic logic [13:0] next_lcg();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[25:12];
    endfunction

    // Monitor: compare each cycle's output with the queued prediction.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                if (frame_o !== e.f || data_mode_o !== e.m) begin
                    n_bad++;
                    $display("FAIL %s: actual frame=%h mode=%b expected frame=%h mode=%b",
                             tag_name(e.tag), frame_o, data_mode_o, e.f, e.m);
                end
                if (e.first_pas) begin
                    n_vec++;
                    if (frame_o == 16'hFF00 || frame_o == 16'h00FF) begin
                        n_bad++;
                        $display("FAIL R9: actual first prbs frame=%h expected not FF00/00FF", frame_o);
                    end
                end
            end
        end
    end

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual run still busy expected finished");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        n_vec++;
        if (frame_o !== 16'h0 || data_mode_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual frame=%h mode=%b expected frame=0000 mode=0", frame_o, data_mode_o);
        end
        rst_n = 1'b1;
        // R1: strobes before any SYNC leave the output at zero.
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, next_lcg(), 0);
        // R10: short SYNC between strobes, held until the next strobe.
        drive(1'b0, 1'b1, '0, 0);
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, '0, 0);
        for (int i = 0; i < 104; i++) drive(1'b1, 1'b0, next_lcg(), 0);
        // R5: payload forced to all ones, then all zeros.
        for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, '0, 1);
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, '0, 2);
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 14'h3FFF, 0);
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 14'h0000, 0);
        // R12: throttled strobes.
        for (int i = 0; i < 60; i++) drive((i % 3) == 0, 1'b0, next_lcg(), 0);
        // R10: restart in data, then again in the alignment phase.
        drive(1'b1, 1'b1, next_lcg(), 0);
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, next_lcg(), 0);
        drive(1'b1, 1'b1, next_lcg(), 0);
        for (int i = 0; i < 80; i++) drive(1'b1, 1'b0, next_lcg(), 1 * (i > 70));
        // R10: SYNC held across gaps while in data, then the sequence again.
        drive(1'b0, 1'b1, '0, 0);
        drive(1'b0, 1'b0, '0, 0);
        for (int i = 0; i < 90; i++) drive((i % 2) == 0, 1'b0, next_lcg(), 0);
        drive(1'b0, 1'b0, '0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule